// File: doc/BRIEF.md
# Isochronous Packet Frame Delimiter

This block sits behind a camera bridge. It receives a byte stream cut into isochronous packets and marks where each video frame starts and ends, for a frame assembler further down. Each input beat carries one byte and flags for the start and end of its packet. A zero-length packet is a single beat with `in_empty` set; its data, start and end flags are ignored. The output is a byte stream in which every beat carries a tag: middle, first or last of frame. Marker beats that carry no byte have `out_nodata` set.

In compressed mode, a frame starts at a packet whose first two bytes are the start-of-image pair 0xFF, 0xD8. The block then emits a last-of-frame marker and replaces those two bytes with a locally stored header, tagged first-of-frame. The rest of the packet follows as middle data. Empty packets can occur inside a compressed frame and do not split it. In raw mode, an empty packet ends the frame. The boundary is held as pending until the next non-empty packet, which is then preceded by a last marker and a first marker. Bytes that arrive before any boundary has been seen pass as middle data. Both sides use a valid/ready handshake.

Top module: `fd_iso_framer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` is 0, and no raw boundary is pending: a raw packet sent right after reset gives only middle beats.
- R2: In compressed mode, a packet of two or more bytes that begins 0xFF then 0xD8 produces, in order: one beat with tag 2 (last) and `out_nodata`=1, then HDR_BYTES beats with tag 1 (first) carrying the header, then the remaining bytes of the packet with tag 0 (middle). The 0xFF and 0xD8 are not forwarded.
- R3: Header byte k is 0xFF for k=0, 0xD8 for k=1, and otherwise the low 8 bits of (k*29) XOR 0x5A.
- R4: In compressed mode, an empty packet is accepted and produces no output beat and no boundary.
- R5: In raw mode, an empty packet produces no output beat by itself. The next non-empty packet is preceded by a tag-2 beat and then a tag-1 beat, both with `out_nodata`=1.
- R6: Several consecutive raw empty packets produce only one last/first pair.
- R7: In raw mode, a packet that begins 0xFF, 0xD8 is plain middle data.
- R8: In compressed mode, a packet that begins with 0xFF not followed by 0xD8, and a one-byte packet holding 0xFF, are forwarded unchanged as middle data.
- R9: Every byte that is not part of a start-of-image pair is forwarded exactly once, in order, tagged 0. This includes packets that arrive before any boundary, which get no first marker.
- R10: A pending raw boundary is discarded once compressed mode is selected.
- R11: While `out_ready` is 0, a valid output beat keeps its tag, data and `out_nodata` stable. During marker and header beats `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_jpeg | input | 1 | 1 selects compressed mode, 0 raw mode |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_empty | input | 1 | Beat stands for a zero-length packet |
| in_sop | input | 1 | Beat is the first byte of its packet |
| in_eop | input | 1 | Beat is the last byte of its packet |
| in_data | input | 8 | Packet byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_tag | output | 2 | 0 middle, 1 first, 2 last of frame |
| out_nodata | output | 1 | Marker beat without a payload byte |
| out_data | output | 8 | Output byte |

## Verification
The hardest situation to reach is a marker or header beat stalled by the downstream while a new packet is already waiting at the input. The stimulus holds `out_ready` low and then sends a start-of-image pair, which the block accepts because that pair produces no output of its own. It then presents a fresh packet start and samples the stalled last marker and `in_ready` over several cycles before it releases the stall. The packet table also runs half its rows under an irregular ready pattern, so header streaming and pending raw boundaries are crossed by stalls at varying offsets.

// File: rtl/fd_pkg.sv
package fd_pkg;

  typedef enum logic [1:0] {
    TAG_MID   = 2'b00,
    TAG_FIRST = 2'b01,
    TAG_LAST  = 2'b10
  } beat_tag_e;

  localparam logic [7:0] SOI_HI = 8'hFF;
  localparam logic [7:0] SOI_LO = 8'hD8;

  // Header content: starts with the image-start pair, then a filler pattern.
  function automatic logic [7:0] hdr_byte(input int unsigned idx);
    if (idx == 0) return SOI_HI;
    if (idx == 1) return SOI_LO;
    return 8'((idx * 29) ^ 32'h5A);
  endfunction

  // True when a beat can open an image-start pair: first byte of a packet
  // that has at least one more byte.
  function automatic logic soi_lead(input logic [7:0] b, input logic sop,
                                    input logic eop);
    return sop && !eop && (b == SOI_HI);
  endfunction

endpackage

// File: rtl/fd_hdr_rom.sv
module fd_hdr_rom #(
  parameter int HDR_BYTES = 8,
  parameter int IDX_W     = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       hdr_out
);
  logic [7:0] rom [HDR_BYTES];

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_rom
    assign rom[g] = fd_pkg::hdr_byte(g);
  end

  always_comb begin
    hdr_out = 8'h00;
    if (32'(idx) < HDR_BYTES) hdr_out = rom[idx];
  end
endmodule

// File: rtl/fd_boundary_track.sv
module fd_boundary_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_jpeg,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)         pending <= 1'b0;
    else if (mode_jpeg) pending <= 1'b0;
    else if (set_evt)   pending <= 1'b1;
    else if (clr_evt)   pending <= 1'b0;
  end

  AST_PEND_DROP_JPEG: assert property (@(posedge clk) disable iff (!rst_n)
    mode_jpeg |=> !pending); // R10
  AST_PEND_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(set_evt)); // R5
endmodule

// File: rtl/fd_seq_fsm.sv
module fd_seq_fsm
  import fd_pkg::*;
#(
  parameter int HDR_BYTES = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_jpeg,
  input  logic             pending,
  input  logic [7:0]       rom_byte,
  output logic [IDX_W-1:0] hdr_idx,
  output logic             set_evt,
  output logic             clr_evt,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_empty,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_tag,
  output logic             out_nodata,
  output logic [7:0]       out_data
);
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_BYTES - 1);

  typedef enum logic [2:0] {
    ST_PASS, ST_SOI2, ST_FLUSH, ST_JLAST, ST_HDR, ST_RLAST, ST_RFIRST
  } st_e;

  st_e state, state_nxt;

  // Named events for the assertions and the control below.
  logic pass_empty, pass_rawcut, pass_soi, soi_match;
  assign pass_empty  = in_valid && in_empty;
  assign pass_rawcut = in_valid && !in_empty && in_sop && !mode_jpeg && pending;
  assign pass_soi    = in_valid && !in_empty && mode_jpeg &&
                       soi_lead(in_data, in_sop, in_eop);
  assign soi_match   = in_valid && !in_empty && (in_data == SOI_LO);

  always_comb begin
    state_nxt  = state;
    out_valid  = 1'b0;
    out_tag    = TAG_MID;
    out_nodata = 1'b0;
    out_data   = in_data;
    in_ready   = 1'b0;
    unique case (state)
      ST_PASS: begin
        if (pass_empty) begin
          in_ready = 1'b1;
        end else if (pass_rawcut) begin
          state_nxt = ST_RLAST;
        end else if (pass_soi) begin
          in_ready  = 1'b1;
          state_nxt = ST_SOI2;
        end else begin
          out_valid = in_valid;
          in_ready  = out_ready;
        end
      end
      ST_SOI2: begin
        if (in_valid) begin
          if (soi_match) begin
            in_ready  = 1'b1;
            state_nxt = ST_JLAST;
          end else begin
            state_nxt = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        out_valid = 1'b1;
        out_data  = SOI_HI;
        if (out_ready) state_nxt = ST_PASS;
      end
      ST_JLAST, ST_RLAST: begin
        out_valid  = 1'b1;
        out_tag    = TAG_LAST;
        out_nodata = 1'b1;
        out_data   = 8'h00;
        if (out_ready) state_nxt = (state == ST_JLAST) ? ST_HDR : ST_RFIRST;
      end
      ST_HDR: begin
        out_valid = 1'b1;
        out_tag   = TAG_FIRST;
        out_data  = rom_byte;
        if (out_ready && hdr_idx == HDR_LAST) state_nxt = ST_PASS;
      end
      ST_RFIRST: begin
        out_valid  = 1'b1;
        out_tag    = TAG_FIRST;
        out_nodata = 1'b1;
        out_data   = 8'h00;
        if (out_ready) state_nxt = ST_PASS;
      end
      default: state_nxt = ST_PASS;
    endcase
  end

  assign set_evt = (state == ST_PASS) && pass_empty && !mode_jpeg;
  assign clr_evt = (state == ST_RFIRST) && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_PASS;
      hdr_idx <= '0;
    end else begin
      state <= state_nxt;
      if (state == ST_HDR && out_ready)
        hdr_idx <= (hdr_idx == HDR_LAST) ? '0 : hdr_idx + 1'b1;
    end
  end

  AST_MARK_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag != TAG_MID) |-> !in_ready); // R11
  AST_LAST_THEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_tag == TAG_LAST) |=>
      (out_valid && out_tag == TAG_FIRST)); // R2
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && state != ST_PASS) |=>
      (out_valid && $stable(out_tag) && $stable(out_data) &&
       $stable(out_nodata))); // R11
  AST_HDR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_idx <= HDR_LAST); // R3
  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PASS && pass_empty) |-> !out_valid); // R4
endmodule

// File: rtl/fd_iso_framer.sv
module fd_iso_framer #(
  parameter int HDR_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_jpeg,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_empty,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_tag,
  output logic       out_nodata,
  output logic [7:0] out_data
);
  localparam int IDX_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;

  logic [IDX_W-1:0] hdr_idx;
  logic [7:0]       rom_byte;
  logic             pending, set_evt, clr_evt;

  fd_hdr_rom #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_rom (
    .idx     (hdr_idx),
    .hdr_out (rom_byte)
  );

  fd_boundary_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_jpeg (mode_jpeg),
    .set_evt   (set_evt),
    .clr_evt   (clr_evt),
    .pending   (pending)
  );

  fd_seq_fsm #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_jpeg  (mode_jpeg),
    .pending    (pending),
    .rom_byte   (rom_byte),
    .hdr_idx    (hdr_idx),
    .set_evt    (set_evt),
    .clr_evt    (clr_evt),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_empty   (in_empty),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tag    (out_tag),
    .out_nodata (out_nodata),
    .out_data   (out_data)
  );
endmodule

// File: tb/fd_iso_framer_bench.sv
module fd_iso_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  typedef struct packed {
    logic       jpeg;
    logic [3:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] nbeats;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd3, 8'h11, 8'h22, 8'd3,  8'd1},  // R1 raw right after reset
    '{1'b1, 4'd4, 8'hFF, 8'hD8, 8'd11, 8'd2},  // R2 R3 image start + 2 bytes
    '{1'b1, 4'd0, 8'h00, 8'h00, 8'd0,  8'd4},  // R4 empty inside frame
    '{1'b1, 4'd3, 8'hFF, 8'h00, 8'd3,  8'd8},  // R8 FF not followed by D8
    '{1'b1, 4'd1, 8'hFF, 8'h00, 8'd1,  8'd8},  // R8 one-byte FF
    '{1'b1, 4'd2, 8'hFF, 8'hD8, 8'd9,  8'd2},  // R2 pair only
    '{1'b0, 4'd2, 8'hFF, 8'hD8, 8'd2,  8'd7},  // R7 raw pair is data
    '{1'b0, 4'd0, 8'h00, 8'h00, 8'd0,  8'd5},  // R5 raw empty
    '{1'b0, 4'd0, 8'h00, 8'h00, 8'd0,  8'd6},  // R6 second raw empty
    '{1'b0, 4'd3, 8'h31, 8'h32, 8'd5,  8'd5},  // R5 R6 one marker pair
    '{1'b0, 4'd1, 8'h44, 8'h00, 8'd1,  8'd9},  // R9 mid data
    '{1'b0, 4'd0, 8'h00, 8'h00, 8'd0,  8'd5},  // R5 pending again
    '{1'b1, 4'd2, 8'hAA, 8'hBB, 8'd2,  8'd10}, // R10 mode switch drops it
    '{1'b0, 4'd2, 8'h5C, 8'h5D, 8'd2,  8'd10}  // R10 no markers follow
  };

  logic clk = 1'b0, rst_n = 1'b0, mode_jpeg = 1'b0;
  logic in_valid = 1'b0, in_empty = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_nodata;
  logic out_ready = 1'b1;
  logic [1:0] out_tag;
  logic [7:0] out_data;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit stall_en = 1'b0, force_lo = 1'b0, done = 1'b0;
  logic [10:0] cap [$];
  logic [10:0] expq [$];
  bit m_pend = 1'b0;

  fd_iso_framer #(.HDR_BYTES(HB)) u_fd_iso_framer (
    .clk(clk), .rst_n(rst_n), .mode_jpeg(mode_jpeg),
    .in_valid(in_valid), .in_ready(in_ready), .in_empty(in_empty),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_nodata(out_nodata), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= force_lo ? 1'b0 : (stall_en ? (cyc % 3 != 1) : 1'b1);
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) cap.push_back({out_tag, out_nodata, out_data});

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Header byte k: 0xFF, 0xD8, then 29*k mixed with 0x5A (R3).
  function automatic logic [7:0] hdr_exp(input int k);
    if (k == 0) return 8'hFF;
    if (k == 1) return 8'hD8;
    return 8'(((k << 4) + (k << 3) + (k << 2) + k) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] pkt_byte(input int p, input int i, input vec_t v);
    if (i == 0) return v.b0;
    if (i == 1) return v.b1;
    return 8'(p * 16 + i);
  endfunction

  task automatic drive_beat(input logic emp, input logic sop, input logic eop,
                            input logic [7:0] d);
    in_valid = 1'b1; in_empty = emp; in_sop = sop; in_eop = eop; in_data = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_empty = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic model_pkt(input int p, input vec_t v);
    int st;
    st = 0;
    if (v.jpeg) m_pend = 1'b0;
    if (v.len == 0) begin
      if (!v.jpeg) m_pend = 1'b1;
      return;
    end
    if (v.jpeg && v.len >= 2 && v.b0 == 8'hFF && v.b1 == 8'hD8) begin
      expq.push_back({2'd2, 1'b1, 8'h00});
      for (int k = 0; k < HB; k++) expq.push_back({2'd1, 1'b0, hdr_exp(k)});
      st = 2;
    end else if (!v.jpeg && m_pend) begin
      expq.push_back({2'd2, 1'b1, 8'h00});
      expq.push_back({2'd1, 1'b1, 8'h00});
      m_pend = 1'b0;
    end
    for (int i = st; i < int'(v.len); i++) expq.push_back({2'd0, 1'b0, pkt_byte(p, i, v)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) begin
      @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    @(posedge clk); #1;

    for (int p = 0; p < NV; p++) begin
      int base;
      int eb;
      vec_t v;
      v = TBL[p];
      stall_en = p[0];
      mode_jpeg = v.jpeg;
      base = cap.size();
      eb = expq.size();
      model_pkt(p, v);
      if (v.len == 0) drive_beat(1'b1, 1'b1, 1'b1, 8'h00);
      else for (int i = 0; i < int'(v.len); i++)
        drive_beat(1'b0, i == 0, i == int'(v.len) - 1, pkt_byte(p, i, v));
      repeat (40) @(posedge clk); #1;
      check($sformatf("R%0d", v.req), $sformatf("beats of packet %0d", p),
            cap.size() - base, int'(v.nbeats));
      for (int j = 0; j < expq.size() - eb && base + j < cap.size(); j++)
        check($sformatf("R%0d", v.req), $sformatf("packet %0d beat %0d", p, j),
              int'(cap[base + j]), int'(expq[eb + j]));
    end

    // R11: stalled last marker with a new packet waiting.
    stall_en = 1'b0;
    force_lo = 1'b1;
    mode_jpeg = 1'b1;
    @(posedge clk); #1;
    drive_beat(1'b0, 1'b1, 1'b0, 8'hFF);
    drive_beat(1'b0, 1'b0, 1'b1, 8'hD8);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h55;
    repeat (3) begin
      @(negedge clk);
      check("R11", "stalled valid", int'(out_valid), 1);
      check("R11", "stalled tag/nodata", int'({out_tag, out_nodata}), 3'b101);
      check("R11", "in_ready in marker", int'(in_ready), 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    begin
      int base;
      base = cap.size();
      force_lo = 1'b0;
      repeat (40) @(posedge clk); #1;
      check("R11", "beats after release", cap.size() - base, 1 + HB);
      if (cap.size() >= base + 1 + HB) begin
        check("R11", "first beat after release", int'(cap[base]), int'({2'd2, 1'b1, 8'h00}));
        check("R3", "last header byte", int'(cap[base + HB]),
              int'({2'd1, 1'b0, hdr_exp(HB - 1)}));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule